// File: doc/BRIEF.md
# UART Word-Wide FIFO Access Port

This block sits between a host register port and the two byte queues of a UART channel. Data can move one character per access or four characters per 32-bit access. A word read at the receive word address removes up to four received characters in one access. A word write at the transmit word address queues four characters in one access. The byte data address at offset 0x00 still moves one character per access, for any remainder of fewer than four characters.

One packed status word lets the host decide what to do with a single read. It holds the receive fill level, the transmit free space, an interrupt-idle flag and the line-status flags. The receive queue is filled from a line-side byte input that tags each character with parity and framing errors. The transmit queue is drained by a line-side take strobe. Bit serialisation is not part of this block.

Top module: `uart_burst_port`

## Requirements
- R1: After reset the status word (offset 0x9C) reads 0x2010_0000 plus the transmit free count in bits 15:8, the queues are empty and `tx_out_valid` is low.
- R2: Status bits 7:0 give the receive fill count and bits 15:8 the transmit free count, each saturating at 255 and updated on the clock edge that performs the push or pop.
- R3: A read at 0xA4 returns min(4, fill) characters, with the oldest in bits 7:0 and each later one in the next byte lane. Unused lanes read zero, and only the returned characters are removed.
- R4: A write at 0xA0 with at least four free entries queues all four bytes, and bits 7:0 leave the transmit queue first.
- R5: A write at 0xA0 with fewer than four free entries, or a byte write with no free entry, queues nothing and sets the sticky overflow flag at status bit 16.
- R6: A read at 0x00 returns the oldest received character in bits 7:0 and removes it. When the queue is empty it returns zero and removes nothing. A write at 0x00 queues bits 7:0 as one character.
- R7: A line character that arrives when the receive queue is full is discarded and sets status bit 25. A write at 0x02 with bit 1 set (for example 0x43) empties the receive queue and clears bit 25.
- R8: A write at 0x02 with bit 2 set empties the transmit queue and clears status bit 16.
- R9: Status bits 26 and 27 show the parity and framing error tags of the oldest received character, and read zero when the receive queue is empty.
- R10: Status bit 24 is set while the receive queue holds data, and bit 29 is set while the transmit queue is empty. Bit 20 is set exactly when none of bits 16, 24, 25, 26 and 27 is set, meaning there is nothing to service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | ADDR_W | Host byte offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe; read data is valid in the same cycle |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, zero when no read is active |
| rx_in_valid | input | 1 | Line-side received character strobe |
| rx_in_byte | input | 8 | Received character |
| rx_in_perr | input | 1 | Parity error tag of the character |
| rx_in_ferr | input | 1 | Framing error tag of the character |
| tx_out_valid | output | 1 | Transmit queue holds a character |
| tx_out_byte | output | 8 | Oldest transmit character |
| tx_out_take | input | 1 | Line side removes the oldest transmit character |

## Verification
A queue pointer or count that drifts shows up at the ports on the next status read: the fill or free field is wrong, and a later word read returns characters out of order or with non-zero unused lanes. A lost or wrongly kept sticky flag appears at once in bits 16, 25 or 20. A queue that accepts part of an oversized word write shows stray characters at `tx_out_byte` on the following takes. The tests run a deep receive queue so that the count field reaches saturation, and a shallow transmit queue so that overflow is reached within a few accesses.

// File: rtl/ubf_pkg.sv
package ubf_pkg;
   localparam int unsigned LANES     = 4;
   localparam int unsigned OFS_DATA  = 'h000;
   localparam int unsigned OFS_FCTL  = 'h002;
   localparam int unsigned OFS_STAT  = 'h09C;
   localparam int unsigned OFS_TXW   = 'h0A0;
   localparam int unsigned OFS_RXW   = 'h0A4;

   localparam int unsigned ST_TXOVF  = 16;
   localparam int unsigned ST_IDLE   = 20;
   localparam int unsigned ST_DR     = 24;
   localparam int unsigned ST_OE     = 25;
   localparam int unsigned ST_PE     = 26;
   localparam int unsigned ST_FE     = 27;
   localparam int unsigned ST_THRE   = 29;

   localparam int unsigned FC_RXCLR  = 1;
   localparam int unsigned FC_TXCLR  = 2;

   typedef struct packed {
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_ent_t;
endpackage

// File: rtl/ubf_lane_fifo.sv
module ubf_lane_fifo #(
   parameter  int unsigned WIDTH = 8,
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned LANES = 4,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1),
   localparam int unsigned LW    = $clog2(LANES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic [LW-1:0]          push_n,
   input  logic [LANES*WIDTH-1:0] push_data,
   input  logic [LW-1:0]          pop_n,
   output logic [LANES*WIDTH-1:0] head_data,
   output logic [CW-1:0]          count
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;

   if (DEPTH < LANES) begin : g_depth_bad
      $error("queue depth must hold one full word");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_pow2_bad
      $error("queue depth must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         wp  <= wp + AW'(push_n);
         rp  <= rp + AW'(pop_n);
         cnt <= cnt + CW'(push_n) - CW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (!flush && (LW'(i) < push_n))
            mem[wp + AW'(i)] <= push_data[i*WIDTH +: WIDTH];
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_head
      assign head_data[g*WIDTH +: WIDTH] = mem[rp + AW'(g)];
   end

   assign count = cnt;
endmodule

// File: rtl/ubf_status_word.sv
module ubf_status_word
   import ubf_pkg::*;
#(
   parameter int unsigned RX_CW = 5,
   parameter int unsigned TX_CW = 5
) (
   input  logic [RX_CW-1:0] rx_count,
   input  logic [TX_CW-1:0] tx_free,
   input  logic             tx_empty,
   input  logic             tx_ovf,
   input  logic             rx_ovr,
   input  logic             head_perr,
   input  logic             head_ferr,
   output logic [31:0]      word
);
   logic [7:0] rx8, tx8;
   logic       dr;

   if (RX_CW > 8) begin : g_rx_sat
      assign rx8 = (rx_count > RX_CW'(255)) ? 8'hFF : rx_count[7:0];
   end else begin : g_rx_plain
      assign rx8 = 8'(rx_count);
   end

   if (TX_CW > 8) begin : g_tx_sat
      assign tx8 = (tx_free > TX_CW'(255)) ? 8'hFF : tx_free[7:0];
   end else begin : g_tx_plain
      assign tx8 = 8'(tx_free);
   end

   assign dr = (rx_count != '0);

   always_comb begin
      word            = '0;
      word[7:0]       = rx8;
      word[15:8]      = tx8;
      word[ST_TXOVF]  = tx_ovf;
      word[ST_DR]     = dr;
      word[ST_OE]     = rx_ovr;
      word[ST_PE]     = head_perr & dr;
      word[ST_FE]     = head_ferr & dr;
      word[ST_THRE]   = tx_empty;
      word[ST_IDLE]   = ~(tx_ovf | dr | rx_ovr | (head_perr & dr) | (head_ferr & dr));
   end
endmodule

// File: rtl/ubf_host_decode.sv
module ubf_host_decode
   import ubf_pkg::*;
#(
   parameter  int unsigned ADDR_W = 12,
   parameter  int unsigned RX_CW  = 5,
   parameter  int unsigned TX_CW  = 5,
   localparam int unsigned LW     = $clog2(LANES + 1)
) (
   input  logic [ADDR_W-1:0]  h_addr,
   input  logic               h_wr,
   input  logic               h_rd,
   input  logic [31:0]        h_wdata,
   input  logic [RX_CW-1:0]   rx_count,
   input  logic [TX_CW-1:0]   tx_free,
   input  logic [LANES*8-1:0] rx_head,
   input  logic [31:0]        status,
   output logic [LW-1:0]      rx_pop_n,
   output logic [LW-1:0]      tx_push_n,
   output logic [LANES*8-1:0] tx_push_data,
   output logic               rx_flush,
   output logic               tx_flush,
   output logic               tx_ovf_set,
   output logic [31:0]        h_rdata
);
   logic hit_data, hit_fctl, hit_stat, hit_txw, hit_rxw;
   logic [LW-1:0]      rx_take;
   logic [LANES*8-1:0] rx_word;
   logic               tx_room_word, tx_room_byte;

   assign hit_data = (h_addr == ADDR_W'(OFS_DATA));
   assign hit_fctl = (h_addr == ADDR_W'(OFS_FCTL));
   assign hit_stat = (h_addr == ADDR_W'(OFS_STAT));
   assign hit_txw  = (h_addr == ADDR_W'(OFS_TXW));
   assign hit_rxw  = (h_addr == ADDR_W'(OFS_RXW));

   assign tx_room_word = (tx_free >= TX_CW'(LANES));
   assign tx_room_byte = (tx_free != '0);

   always_comb begin
      if (rx_count >= RX_CW'(LANES)) rx_take = LW'(LANES);
      else                           rx_take = LW'(rx_count);
      for (int i = 0; i < LANES; i++)
         rx_word[i*8 +: 8] = (LW'(i) < rx_take) ? rx_head[i*8 +: 8] : 8'h00;
   end

   always_comb begin
      rx_pop_n = '0;
      if (h_rd && hit_rxw)                         rx_pop_n = rx_take;
      else if (h_rd && hit_data && rx_count != '0) rx_pop_n = LW'(1);
   end

   always_comb begin
      tx_push_n    = '0;
      tx_push_data = h_wdata[LANES*8-1:0];
      tx_ovf_set   = 1'b0;
      if (h_wr && hit_txw) begin
         if (tx_room_word) tx_push_n  = LW'(LANES);
         else              tx_ovf_set = 1'b1;
      end else if (h_wr && hit_data) begin
         if (tx_room_byte) tx_push_n  = LW'(1);
         else              tx_ovf_set = 1'b1;
      end
   end

   assign rx_flush = h_wr && hit_fctl && h_wdata[FC_RXCLR];
   assign tx_flush = h_wr && hit_fctl && h_wdata[FC_TXCLR];

   always_comb begin
      h_rdata = '0;
      if (h_rd) begin
         if (hit_rxw)                          h_rdata = 32'(rx_word);
         else if (hit_stat)                    h_rdata = status;
         else if (hit_data && rx_count != '0)  h_rdata = {24'h0, rx_head[7:0]};
      end
   end
endmodule

// File: rtl/uart_burst_port.sv
module uart_burst_port
   import ubf_pkg::*;
#(
   parameter int unsigned RX_DEPTH = 16,
   parameter int unsigned TX_DEPTH = 16,
   parameter int unsigned ADDR_W   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [31:0]       h_wdata,
   output logic [31:0]       h_rdata,
   input  logic              rx_in_valid,
   input  logic [7:0]        rx_in_byte,
   input  logic              rx_in_perr,
   input  logic              rx_in_ferr,
   output logic              tx_out_valid,
   output logic [7:0]        tx_out_byte,
   input  logic              tx_out_take
);
   localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1);
   localparam int unsigned TX_CW = $clog2(TX_DEPTH + 1);
   localparam int unsigned LW    = $clog2(LANES + 1);
   localparam int unsigned EW    = $bits(rx_ent_t);

   if (ADDR_W < 8) begin : g_addr_bad
      $error("address width too small for the register offsets");
   end

   logic [RX_CW-1:0]    rx_count;
   logic [TX_CW-1:0]    tx_count, tx_free;
   logic [LW-1:0]       rx_push_n, rx_pop_n, tx_push_n, tx_pop_n;
   logic [LANES*EW-1:0] rx_push_data, rx_head_raw;
   logic [LANES*8-1:0]  rx_head, tx_push_data, tx_head;
   logic                rx_flush, tx_flush, tx_ovf_set;
   logic                rx_full;
   logic                oe_q, txovf_q;
   logic [31:0]         status;
   rx_ent_t             rx_new, rx_first;

   // Line-side receive path
   assign rx_full   = (rx_count == RX_CW'(RX_DEPTH));
   assign rx_new    = '{ferr: rx_in_ferr, perr: rx_in_perr, data: rx_in_byte};
   assign rx_push_n = (rx_in_valid && !rx_full) ? LW'(1) : '0;
   assign rx_push_data = {{((LANES-1)*EW){1'b0}}, rx_new};

   ubf_lane_fifo #(.WIDTH(EW), .DEPTH(RX_DEPTH), .LANES(LANES)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .push_n    (rx_push_n),
      .push_data (rx_push_data),
      .pop_n     (rx_pop_n),
      .head_data (rx_head_raw),
      .count     (rx_count)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_rx_lane
      assign rx_head[g*8 +: 8] = rx_head_raw[g*EW +: 8];
   end
   assign rx_first = rx_ent_t'(rx_head_raw[EW-1:0]);

   // Line-side transmit path
   assign tx_pop_n     = (tx_out_take && tx_count != '0) ? LW'(1) : '0;
   assign tx_free      = TX_CW'(TX_DEPTH) - tx_count;
   assign tx_out_valid = (tx_count != '0);
   assign tx_out_byte  = tx_head[7:0];

   ubf_lane_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH), .LANES(LANES)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tx_flush),
      .push_n    (tx_push_n),
      .push_data (tx_push_data),
      .pop_n     (tx_pop_n),
      .head_data (tx_head),
      .count     (tx_count)
   );

   // Sticky flags: clearing wins over a same-cycle set
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q    <= 1'b0;
         txovf_q <= 1'b0;
      end else begin
         if (rx_flush)                      oe_q <= 1'b0;
         else if (rx_in_valid && rx_full)   oe_q <= 1'b1;
         if (tx_flush)                      txovf_q <= 1'b0;
         else if (tx_ovf_set)               txovf_q <= 1'b1;
      end
   end

   ubf_status_word #(.RX_CW(RX_CW), .TX_CW(TX_CW)) u_stat (
      .rx_count  (rx_count),
      .tx_free   (tx_free),
      .tx_empty  (tx_count == '0),
      .tx_ovf    (txovf_q),
      .rx_ovr    (oe_q),
      .head_perr (rx_first.perr),
      .head_ferr (rx_first.ferr),
      .word      (status)
   );

   ubf_host_decode #(.ADDR_W(ADDR_W), .RX_CW(RX_CW), .TX_CW(TX_CW)) u_dec (
      .h_addr       (h_addr),
      .h_wr         (h_wr),
      .h_rd         (h_rd),
      .h_wdata      (h_wdata),
      .rx_count     (rx_count),
      .tx_free      (tx_free),
      .rx_head      (rx_head),
      .status       (status),
      .rx_pop_n     (rx_pop_n),
      .tx_push_n    (tx_push_n),
      .tx_push_data (tx_push_data),
      .rx_flush     (rx_flush),
      .tx_flush     (tx_flush),
      .tx_ovf_set   (tx_ovf_set),
      .h_rdata      (h_rdata)
   );
endmodule

// File: rtl/ubf_checker.sv
module ubf_checker #(
   parameter int unsigned RX_CW    = 5,
   parameter int unsigned TX_CW    = 5,
   parameter int unsigned LW       = 3,
   parameter int unsigned TX_DEPTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [RX_CW-1:0] rx_count,
   input logic [TX_CW-1:0] tx_count,
   input logic [LW-1:0]    rx_push_n,
   input logic [LW-1:0]    rx_pop_n,
   input logic [LW-1:0]    tx_push_n,
   input logic             rx_flush,
   input logic             tx_flush,
   input logic             oe_q,
   input logic             txovf_q
);
   // R3
   rx_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rx_pop_n) <= int'(rx_count));

   // R5
   tx_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_count) + int'(tx_push_n)) <= int'(TX_DEPTH));

   // R2
   rx_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_flush) |->
         int'(rx_count) == int'($past(rx_count)) + int'($past(rx_push_n)) - int'($past(rx_pop_n)));

   // R7
   oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> !oe_q);

   // R5
   txovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txovf_q && !tx_flush) |=> txovf_q);
endmodule

bind uart_burst_port ubf_checker #(
   .RX_CW(RX_CW), .TX_CW(TX_CW), .LW(LW), .TX_DEPTH(TX_DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_count  (rx_count),
   .tx_count  (tx_count),
   .rx_push_n (rx_push_n),
   .rx_pop_n  (rx_pop_n),
   .tx_push_n (tx_push_n),
   .rx_flush  (rx_flush),
   .tx_flush  (tx_flush),
   .oe_q      (oe_q),
   .txovf_q   (txovf_q)
);

// File: tb/sim_uart_burst_port.sv
module sim_uart_burst_port;
   localparam int unsigned RXD = 512;
   localparam int unsigned TXD = 8;

   localparam logic [2:0] OP_HRD  = 3'd0;
   localparam logic [2:0] OP_HWR  = 3'd1;
   localparam logic [2:0] OP_LINE = 3'd2;
   localparam logic [2:0] OP_TAKE = 3'd3;

   typedef struct packed {
      logic [2:0]  op;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 39;
   // LINE data: [7:0] char, [8] parity tag, [9] framing tag. TAKE exp: [8] valid, [7:0] char.
   localparam vec_t VECS [NV] = '{
      '{OP_HRD,  12'h09C, 32'h0,         32'h2010_0800, 8'd1},  // R1
      '{OP_LINE, 12'h000, 32'h11,        32'h0,         8'd3},
      '{OP_LINE, 12'h000, 32'h22,        32'h0,         8'd3},
      '{OP_LINE, 12'h000, 32'h33,        32'h0,         8'd3},
      '{OP_LINE, 12'h000, 32'h44,        32'h0,         8'd3},
      '{OP_LINE, 12'h000, 32'h55,        32'h0,         8'd3},
      '{OP_HRD,  12'h09C, 32'h0,         32'h2100_0805, 8'd2},  // R2
      '{OP_HRD,  12'h0A4, 32'h0,         32'h4433_2211, 8'd3},  // R3
      '{OP_HRD,  12'h09C, 32'h0,         32'h2100_0801, 8'd2},  // R2
      '{OP_HRD,  12'h0A4, 32'h0,         32'h0000_0055, 8'd3},  // R3 partial word
      '{OP_HRD,  12'h09C, 32'h0,         32'h2010_0800, 8'd3},  // R3 only one popped
      '{OP_HRD,  12'h000, 32'h0,         32'h0,         8'd6},  // R6 empty read
      '{OP_HWR,  12'h0A0, 32'hDDCC_BBAA, 32'h0,         8'd4},  // R4
      '{OP_HRD,  12'h09C, 32'h0,         32'h0010_0400, 8'd2},  // R2
      '{OP_TAKE, 12'h000, 32'h0,         32'h1AA,       8'd4},  // R4
      '{OP_TAKE, 12'h000, 32'h0,         32'h1BB,       8'd4},
      '{OP_HWR,  12'h000, 32'h5A,        32'h0,         8'd6},  // R6 byte write
      '{OP_HRD,  12'h09C, 32'h0,         32'h0010_0500, 8'd6},
      '{OP_TAKE, 12'h000, 32'h0,         32'h1CC,       8'd4},
      '{OP_TAKE, 12'h000, 32'h0,         32'h1DD,       8'd4},
      '{OP_TAKE, 12'h000, 32'h0,         32'h15A,       8'd6},
      '{OP_HRD,  12'h09C, 32'h0,         32'h2010_0800, 8'd10}, // R10
      '{OP_LINE, 12'h000, 32'h166,       32'h0,         8'd9},
      '{OP_LINE, 12'h000, 32'h277,       32'h0,         8'd9},
      '{OP_HRD,  12'h09C, 32'h0,         32'h2500_0802, 8'd9},  // R9 parity at head
      '{OP_HRD,  12'h000, 32'h0,         32'h66,        8'd6},
      '{OP_HRD,  12'h09C, 32'h0,         32'h2900_0801, 8'd9},  // R9 framing at head
      '{OP_HRD,  12'h000, 32'h0,         32'h77,        8'd6},
      '{OP_HWR,  12'h0A0, 32'h0403_0201, 32'h0,         8'd4},
      '{OP_HWR,  12'h0A0, 32'h0807_0605, 32'h0,         8'd4},
      '{OP_HWR,  12'h0A0, 32'hFFFF_FFFF, 32'h0,         8'd5},  // R5 full
      '{OP_HRD,  12'h09C, 32'h0,         32'h0001_0000, 8'd5},  // R5
      '{OP_TAKE, 12'h000, 32'h0,         32'h101,       8'd4},
      '{OP_HWR,  12'h0A0, 32'h1111_1111, 32'h0,         8'd5},  // R5 one free
      '{OP_HRD,  12'h09C, 32'h0,         32'h0001_0100, 8'd10}, // R10
      '{OP_TAKE, 12'h000, 32'h0,         32'h102,       8'd5},  // R5 nothing partial queued
      '{OP_HWR,  12'h002, 32'h04,        32'h0,         8'd8},  // R8
      '{OP_HRD,  12'h09C, 32'h0,         32'h2010_0800, 8'd8},  // R8
      '{OP_TAKE, 12'h000, 32'h0,         32'h000,       8'd8}   // R8 queue empty
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] h_addr = '0;
   logic        h_wr = 1'b0, h_rd = 1'b0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        rx_in_valid = 1'b0, rx_in_perr = 1'b0, rx_in_ferr = 1'b0;
   logic [7:0]  rx_in_byte = '0;
   logic        tx_out_valid;
   logic [7:0]  tx_out_byte;
   logic        tx_out_take = 1'b0;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   uart_burst_port #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .ADDR_W(12)) u0 (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .rx_in_valid(rx_in_valid),
      .rx_in_byte(rx_in_byte), .rx_in_perr(rx_in_perr), .rx_in_ferr(rx_in_ferr),
      .tx_out_valid(tx_out_valid), .tx_out_byte(tx_out_byte), .tx_out_take(tx_out_take)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One access per cycle: drive at the falling edge, sample 2 ns later, release after the rising edge
   task automatic step(input logic [2:0] op, input logic [11:0] addr, input logic [31:0] data,
                       output logic [31:0] got);
      @(negedge clk);
      h_addr = addr;
      h_wdata = data;
      h_rd = (op == OP_HRD);
      h_wr = (op == OP_HWR);
      rx_in_valid = (op == OP_LINE);
      rx_in_byte = data[7:0];
      rx_in_perr = data[8];
      rx_in_ferr = data[9];
      tx_out_take = (op == OP_TAKE);
      #2;
      if (op == OP_TAKE) got = {23'h0, tx_out_valid, tx_out_valid ? tx_out_byte : 8'h00};
      else               got = h_rdata;
      @(posedge clk);
      #1;
      h_rd = 1'b0; h_wr = 1'b0; rx_in_valid = 1'b0; tx_out_take = 1'b0;
      rx_in_perr = 1'b0; rx_in_ferr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         step(VECS[k].op, VECS[k].addr, VECS[k].data, got);
         if (VECS[k].op == OP_HRD || VECS[k].op == OP_TAKE)
            check($sformatf("R%0d vec%0d", VECS[k].req, k), got, VECS[k].exp);
      end

      // R2 saturation of the fill field at 255
      for (int k = 0; k < 300; k++) step(OP_LINE, 12'h000, 32'(k[7:0]), got);
      step(OP_HRD, 12'h09C, 32'h0, got);
      check("R2 fill saturates", got, 32'h2100_08FF);

      // R7 fill to depth, then one more character is lost
      for (int k = 300; k < RXD; k++) step(OP_LINE, 12'h000, 32'h0, got);
      step(OP_HRD, 12'h09C, 32'h0, got);
      check("R7 full without overrun", got, 32'h2100_08FF);
      step(OP_LINE, 12'h000, 32'hEE, got);
      step(OP_HRD, 12'h09C, 32'h0, got);
      check("R7 overrun flagged", got, 32'h2300_08FF);
      step(OP_HRD, 12'h000, 32'h0, got);
      check("R6 oldest kept after overrun", got, 32'h0);
      step(OP_HWR, 12'h002, 32'h43, got);
      step(OP_HRD, 12'h09C, 32'h0, got);
      check("R7 clear with 0x43", got, 32'h2010_0800);

      // R1 reset with both queues holding data
      step(OP_LINE, 12'h000, 32'h31, got);
      step(OP_HWR, 12'h0A0, 32'h1234_5678, got);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      step(OP_HRD, 12'h09C, 32'h0, got);
      check("R1 status after reset", got, 32'h2010_0800);
      step(OP_TAKE, 12'h000, 32'h0, got);
      check("R1 transmit empty after reset", got, 32'h0);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule